// File: doc/BRIEF.md
# Strict-Priority/WFQ Transmit Arbiter

The block chooses, once per clock, which of five transmit clients may send next. Client 0 is a management source. Clients 1 and 2 are debug sources. Clients 3 and 4 are traffic class 0 and traffic class 1. Each client raises a request line and presents the byte length of the frame it would send. The arbiter answers with a one-hot grant in the following cycle. Frame storage and the datapath belong to the surrounding logic.

Two service disciplines are mixed. Strict clients are ranked by a remappable table of five priority positions. A programmable slot limit caps how many strict grants may follow one another before a fair slot is forced. In a fair slot, the clients in the weighted-fair pool compete on credit: the largest non-negative credit wins, and the frame length is charged against it. When the pool has no requesters, the fair slot goes round-robin over every requester. When every requesting pool member has a negative credit, the pool is replenished from per-client weights, each credit capped at a per-client bound. A mode bit switches the weighted-fair pool off and moves one chosen traffic class into the strict set.

Software configures the block through a single-cycle write port. It is normally programmed while traffic is idle.

Top module: `tx_prio_wfq_arb`

## Requirements
- R1: During reset the grant is zero. After reset the configuration is:
  - priority table 0x4688, which ranks client k at position k,
  - strict set 0x07,
  - weighted-fair set 0x18,
  - slot limit 4,
  - weighted-fair mode on, with traffic class 0 selected,
  - every weight 0x2800 and every bound 0x5000,
  - every credit 0,
  - both rotation pointers on client 4.
- R2: `gnt_o` is one-hot or zero, and bit k means client k. A grant appears one cycle after the request it answers and only to a client that requested in that cycle. A cycle with no requests produces no grant the next cycle.
- R3: In a strict slot the winner is the requesting strict client named at the highest priority position. Position p is table bits 3p+2:3p, and position 4 ranks highest. A table entry of 5, 6 or 7 names no client.
- R4: A strict slot is used only while fewer strict grants than the slot limit have occurred since the last fair grant. Otherwise the cycle is a fair slot, and a fair grant resets that count.
- R5: A fair slot with no requesting weighted-fair client grants round-robin over all requesters. The search starts at the client after the last round-robin winner and proceeds in ascending order modulo 5. With a slot limit of 0 and an empty pool, this gives pure round-robin.
- R6: A fair slot with pool requesters grants the requesting pool member with the largest non-negative credit. Ties go to the first such client in ascending order after the last weighted-fair winner. That client's `len_i` byte count is subtracted from its credit.
- R7: If every requesting pool member has a negative credit, the cycle grants nothing. Every pool member's credit becomes min(credit + weight, bound).
- R8: With mode bit 0 clear, the pool is empty. Mode bit 1 then adds traffic class 1 (client 4) to the strict set when set, and traffic class 0 (client 3) when clear.
- R9: Write addresses:
  - 0x00: priority table, bits 14:0.
  - 0x01: strict set, bits 4:0.
  - 0x02: weighted-fair set, bits 4:0.
  - 0x03: slot limit.
  - 0x04: mode. Bit 0 enables weighted-fair service; bit 1 selects the traffic class.
  - 0x08+k: weight of client k.
  - 0x10+k: bound of client k.

  A write affects decisions from the next cycle on.
- R10: A client present in both the strict set and the weighted-fair set is served only as a strict client.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Request per client, bit k for client k |
| len_i | input | 5*LEN_W | Frame byte count per client, client k in bits k*LEN_W +: LEN_W |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration write address |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| gnt_o | output | 5 | Registered one-hot grant |

## Verification
The assertions assume the following about the inputs:
- Requests and lengths are stable around each rising edge.
- A grant is judged only against the request vector of the previous cycle.
- Nothing tracks how the request relates to frame completion.

The work-conserving property expects that a configuration write never removes the chance of a grant. It holds because the configuration registers are read, not changed, during a decision.

The stimulus follows these rules:
- All inputs change on falling edges only.
- Configuration writes are issued with every request low.
- Lengths stay well inside `LEN_W`.
- Credits stay within the signed credit range the design sizes for.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
    localparam int NCLI   = 5;
    localparam int CID_W  = 3;
    localparam int NPOS   = 5;
    localparam int MAP_W  = NPOS * CID_W;
    localparam int CFG_AW = 5;
    localparam int TC0_ID = 3;
    localparam int TC1_ID = 4;

    localparam logic [CFG_AW-1:0] A_MAP    = 5'h00;
    localparam logic [CFG_AW-1:0] A_STRICT = 5'h01;
    localparam logic [CFG_AW-1:0] A_WFQ    = 5'h02;
    localparam logic [CFG_AW-1:0] A_SLOTS  = 5'h03;
    localparam logic [CFG_AW-1:0] A_MODE   = 5'h04;
    localparam logic [1:0]        G_WT     = 2'b01;
    localparam logic [1:0]        G_BND    = 2'b10;
endpackage

// File: rtl/txarb_cfg.sv
module txarb_cfg
    import txarb_pkg::*;
#(
    parameter int SLOT_W = 8,
    parameter int WT_W   = 16,
    parameter int DATA_W = 32,
    parameter logic [SLOT_W-1:0] SLOTS_RST = 4,
    parameter logic [WT_W-1:0]   WT_RST    = 16'h2800,
    parameter logic [WT_W-1:0]   BND_RST   = 16'h5000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [CFG_AW-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [MAP_W-1:0]               map_o,
    output logic [NCLI-1:0]                strict_o,
    output logic [NCLI-1:0]                wfq_o,
    output logic [SLOT_W-1:0]              slots_o,
    output logic                           ets_en_o,
    output logic                           hi_tc_o,
    output logic [NCLI-1:0][WT_W-1:0]      wt_o,
    output logic [NCLI-1:0][WT_W-1:0]      bnd_o
);
    typedef struct packed {
        logic [MAP_W-1:0]          map;
        logic [NCLI-1:0]           strict;
        logic [NCLI-1:0]           wfq;
        logic [SLOT_W-1:0]         slots;
        logic                      ets_en;
        logic                      hi_tc;
        logic [NCLI-1:0][WT_W-1:0] wt;
        logic [NCLI-1:0][WT_W-1:0] bnd;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        map:    15'h4688,
        strict: 5'h07,
        wfq:    5'h18,
        slots:  SLOTS_RST,
        ets_en: 1'b1,
        hi_tc:  1'b0,
        wt:     {NCLI{WT_RST}},
        bnd:    {NCLI{BND_RST}}
    };

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            if (addr_i == A_MAP)         cfg_d.map    = wdata_i[MAP_W-1:0];
            else if (addr_i == A_STRICT) cfg_d.strict = wdata_i[NCLI-1:0];
            else if (addr_i == A_WFQ)    cfg_d.wfq    = wdata_i[NCLI-1:0];
            else if (addr_i == A_SLOTS)  cfg_d.slots  = wdata_i[SLOT_W-1:0];
            else if (addr_i == A_MODE) begin
                cfg_d.ets_en = wdata_i[0];
                cfg_d.hi_tc  = wdata_i[1];
            end else if (addr_i[CFG_AW-1:CFG_AW-2] == G_WT && int'(addr_i[2:0]) < NCLI)
                cfg_d.wt[addr_i[2:0]] = wdata_i[WT_W-1:0];
            else if (addr_i[CFG_AW-1:CFG_AW-2] == G_BND && int'(addr_i[2:0]) < NCLI)
                cfg_d.bnd[addr_i[2:0]] = wdata_i[WT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign map_o    = cfg_q.map;
    assign strict_o = cfg_q.strict;
    assign wfq_o    = cfg_q.wfq;
    assign slots_o  = cfg_q.slots;
    assign ets_en_o = cfg_q.ets_en;
    assign hi_tc_o  = cfg_q.hi_tc;
    assign wt_o     = cfg_q.wt;
    assign bnd_o    = cfg_q.bnd;
endmodule

// File: rtl/txarb_prio_pick.sv
module txarb_prio_pick
    import txarb_pkg::*;
(
    input  logic [MAP_W-1:0] map_i,
    input  logic [NCLI-1:0]  elig_i,
    output logic             hit_o,
    output logic [CID_W-1:0] idx_o
);
    // Higher positions are visited later and so override lower ones.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int p = 0; p < NPOS; p++) begin
            if (int'(map_i[p*CID_W +: CID_W]) < NCLI) begin
                if (elig_i[map_i[p*CID_W +: CID_W]]) begin
                    hit_o = 1'b1;
                    idx_o = map_i[p*CID_W +: CID_W];
                end
            end
        end
    end
endmodule

// File: rtl/txarb_rr_pick.sv
module txarb_rr_pick
    import txarb_pkg::*;
(
    input  logic [NCLI-1:0]  elig_i,
    input  logic [CID_W-1:0] last_i,
    output logic             hit_o,
    output logic [CID_W-1:0] idx_o
);
    // Scan from farthest to nearest so the nearest eligible client after last_i wins.
    always_comb begin : scan
        int c;
        hit_o = 1'b0;
        idx_o = '0;
        c     = 0;
        for (int k = NCLI; k >= 1; k--) begin
            c = (int'(last_i) + k) % NCLI;
            if (elig_i[c]) begin
                hit_o = 1'b1;
                idx_o = CID_W'(c);
            end
        end
    end
endmodule

// File: rtl/txarb_wfq.sv
module txarb_wfq
    import txarb_pkg::*;
#(
    parameter int WT_W  = 16,
    parameter int LEN_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCLI-1:0]             set_i,
    input  logic [NCLI-1:0]             req_i,
    input  logic                        take_i,
    input  logic [NCLI-1:0][WT_W-1:0]   wt_i,
    input  logic [NCLI-1:0][WT_W-1:0]   bnd_i,
    input  logic [NCLI-1:0][LEN_W-1:0]  len_i,
    output logic                        has_req_o,
    output logic                        hit_o,
    output logic [CID_W-1:0]            idx_o,
    output logic                        refill_o
);
    localparam int CRED_W = ((WT_W > LEN_W) ? WT_W : LEN_W) + 2;

    typedef struct packed {
        logic [NCLI-1:0][CRED_W-1:0] cred;
        logic [CID_W-1:0]            last;
    } wst_t;

    wst_t st_d, st_q;
    logic [NCLI-1:0]  cand, live;
    logic             found;
    logic [CID_W-1:0] best;

    always_comb begin : pick
        int c;
        c     = 0;
        cand  = req_i & set_i;
        for (int i = 0; i < NCLI; i++)
            live[i] = cand[i] & ~st_q.cred[i][CRED_W-1];
        found = 1'b0;
        best  = '0;
        for (int k = NCLI; k >= 1; k--) begin
            c = (int'(st_q.last) + k) % NCLI;
            if (live[c] && (!found || $signed(st_q.cred[c]) >= $signed(st_q.cred[best]))) begin
                found = 1'b1;
                best  = CID_W'(c);
            end
        end
    end

    assign has_req_o = |cand;
    assign hit_o     = take_i & found;
    assign idx_o     = best;
    assign refill_o  = take_i & (|cand) & ~found;

    always_comb begin : upd
        logic signed [CRED_W-1:0] sum;
        logic signed [CRED_W-1:0] cap;
        sum  = '0;
        cap  = '0;
        st_d = st_q;
        if (hit_o) begin
            st_d.cred[best] = st_q.cred[best] - {{(CRED_W-LEN_W){1'b0}}, len_i[best]};
            st_d.last       = best;
        end else if (refill_o) begin
            for (int i = 0; i < NCLI; i++) begin
                if (set_i[i]) begin
                    sum = $signed(st_q.cred[i]) + $signed({{(CRED_W-WT_W){1'b0}}, wt_i[i]});
                    cap = $signed({{(CRED_W-WT_W){1'b0}}, bnd_i[i]});
                    st_d.cred[i] = (sum > cap) ? cap : sum;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cred <= '0;
            st_q.last <= CID_W'(NCLI - 1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tx_prio_wfq_arb.sv
module tx_prio_wfq_arb
    import txarb_pkg::*;
#(
    parameter int SLOT_W = 8,
    parameter int WT_W   = 16,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCLI-1:0]          req_i,
    input  logic [NCLI*LEN_W-1:0]    len_i,
    input  logic                     cfg_we_i,
    input  logic [CFG_AW-1:0]        cfg_addr_i,
    input  logic [DATA_W-1:0]        cfg_wdata_i,
    output logic [NCLI-1:0]          gnt_o
);
    typedef struct packed {
        logic [NCLI-1:0]   gnt;
        logic [SLOT_W-1:0] slot;
        logic [CID_W-1:0]  rr;
    } st_t;

    st_t st_d, st_q;

    logic [MAP_W-1:0]              map;
    logic [NCLI-1:0]               strict_set, wfq_set, eff_strict, eff_wfq, tc_top;
    logic [SLOT_W-1:0]             slots;
    logic                          ets_en, hi_tc;
    logic [NCLI-1:0][WT_W-1:0]     wt, bnd;
    logic [NCLI-1:0][LEN_W-1:0]    len_a;
    logic                          sp_hit, rr_hit, strict_ok;
    logic [CID_W-1:0]              sp_idx, rr_idx, wfq_idx;
    logic                          wfq_has, wfq_hit, wfq_refill;

    assign len_a = len_i;

    txarb_cfg #(.SLOT_W(SLOT_W), .WT_W(WT_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
        .map_o(map), .strict_o(strict_set), .wfq_o(wfq_set), .slots_o(slots),
        .ets_en_o(ets_en), .hi_tc_o(hi_tc), .wt_o(wt), .bnd_o(bnd)
    );

    // Without weighted-fair service one traffic class joins the strict set.
    assign tc_top     = hi_tc ? (NCLI'(1) << TC1_ID) : (NCLI'(1) << TC0_ID);
    assign eff_strict = strict_set | (ets_en ? '0 : tc_top);
    assign eff_wfq    = ets_en ? (wfq_set & ~eff_strict) : '0;

    txarb_prio_pick u_sp (
        .map_i(map), .elig_i(req_i & eff_strict), .hit_o(sp_hit), .idx_o(sp_idx)
    );

    txarb_rr_pick u_rr (
        .elig_i(req_i), .last_i(st_q.rr), .hit_o(rr_hit), .idx_o(rr_idx)
    );

    assign strict_ok = sp_hit && (st_q.slot < slots);

    txarb_wfq #(.WT_W(WT_W), .LEN_W(LEN_W)) u_wfq (
        .clk(clk), .rst_n(rst_n), .set_i(eff_wfq), .req_i(req_i), .take_i(~strict_ok),
        .wt_i(wt), .bnd_i(bnd), .len_i(len_a),
        .has_req_o(wfq_has), .hit_o(wfq_hit), .idx_o(wfq_idx), .refill_o(wfq_refill)
    );

    always_comb begin
        st_d     = st_q;
        st_d.gnt = '0;
        if (strict_ok) begin
            st_d.gnt  = NCLI'(1) << sp_idx;
            st_d.slot = st_q.slot + 1'b1;
        end else if (wfq_has) begin
            if (wfq_hit) begin
                st_d.gnt  = NCLI'(1) << wfq_idx;
                st_d.slot = '0;
            end
        end else if (rr_hit) begin
            st_d.gnt  = NCLI'(1) << rr_idx;
            st_d.slot = '0;
            st_d.rr   = rr_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gnt  <= '0;
            st_q.slot <= '0;
            st_q.rr   <= CID_W'(NCLI - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o = st_q.gnt;
endmodule

// File: rtl/txarb_chk.sv
module txarb_chk
    import txarb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NCLI-1:0] req_i,
    input logic [NCLI-1:0] gnt_o,
    input logic            refill_i
);
    always @(posedge clk)
        if (!rst_n) p_rst_quiet_r1: assert (gnt_o == '0);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    p_only_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~$past(req_i)) == '0);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (gnt_o == '0));

    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_i) && !refill_i) |=> (|gnt_o));

    p_refill_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refill_i |=> (gnt_o == '0));
endmodule

bind tx_prio_wfq_arb txarb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_o(gnt_o), .refill_i(wfq_refill)
);

// File: tb/tx_prio_wfq_arb_tb.sv
module tx_prio_wfq_arb_tb;
    localparam int NC = 5;
    localparam int LW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   req = '0;
    logic [NC*LW-1:0] len_flat = '0;
    logic            cfg_we = 1'b0;
    logic [4:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [NC-1:0]   gnt;

    tx_prio_wfq_arb u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .len_i(len_flat),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .gnt_o(gnt)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int g_cyc = 0;

    // reference configuration and state, reset values from R1
    int m_map = 32'h4688, m_strict = 7, m_wfq = 32'h18, m_slots = 4, m_ets = 1, m_hi = 0;
    int m_wt[NC]  = '{default: 32'h2800};
    int m_bd[NC]  = '{default: 32'h5000};
    int m_cred[NC] = '{default: 0};
    int m_slot = 0, m_rr = 4, m_wl = 4;
    int ln[NC];

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string ktag(input string k);
        if (k == "strict") return "R3 R4";
        if (k == "wfq")    return "R6";
        if (k == "refill") return "R7";
        if (k == "rr")     return "R4 R5";
        return "R2";
    endfunction

    task automatic model_step(input logic [NC-1:0] rq, output logic [NC-1:0] eg, output string kind);
        int es, ew, sp, best, c, cid, s;
        es = m_strict | (m_ets != 0 ? 0 : (m_hi != 0 ? 16 : 8));
        ew = m_ets != 0 ? (m_wfq & ~es & 31) : 0;
        sp = -1;
        for (int p = 0; p < 5; p++) begin
            cid = (m_map >> (3 * p)) & 7;
            if (cid < 5) if (rq[cid] && es[cid]) sp = cid;
        end
        eg = '0;
        kind = "none";
        if (sp >= 0 && m_slot < m_slots) begin
            eg = NC'(1) << sp; m_slot++; kind = "strict";
        end else if ((int'(rq) & ew) != 0) begin
            best = -1;
            for (int k = 5; k >= 1; k--) begin
                c = (m_wl + k) % 5;
                if (rq[c] && ew[c] && m_cred[c] >= 0)
                    if (best < 0 || m_cred[c] >= m_cred[best]) best = c;
            end
            if (best >= 0) begin
                eg = NC'(1) << best; m_cred[best] -= ln[best]; m_wl = best; m_slot = 0; kind = "wfq";
            end else begin
                for (int i = 0; i < 5; i++)
                    if (ew[i]) begin
                        s = m_cred[i] + m_wt[i];
                        m_cred[i] = (s > m_bd[i]) ? m_bd[i] : s;
                    end
                kind = "refill";
            end
        end else if (rq != 0) begin
            for (int k = 5; k >= 1; k--) begin
                c = (m_rr + k) % 5;
                if (rq[c]) best = c;
            end
            eg = NC'(1) << best; m_rr = best; m_slot = 0; kind = "rr";
        end
    endtask

    task automatic drive(input logic [NC-1:0] rq, input string ph);
        logic [NC-1:0] eg;
        string kind;
        for (int i = 0; i < NC; i++) begin
            ln[i] = 64 + ((g_cyc * 97 + i * 211) % 1400);
            len_flat[i*LW +: LW] = LW'(ln[i]);
        end
        req = rq;
        model_step(rq, eg, kind);
        @(negedge clk);
        check({ktag(kind), " ", ph}, gnt, eg);
        g_cyc++;
    endtask

    // R9 register layout
    task automatic cfg_wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 32'(d); req = '0;
        @(negedge clk);
        check("R2 R9 write cycle", gnt, '0);
        cfg_we = 1'b0;
        if (a == 0) m_map = d & 32'h7fff;
        else if (a == 1) m_strict = d & 31;
        else if (a == 2) m_wfq = d & 31;
        else if (a == 3) m_slots = d & 255;
        else if (a == 4) begin m_ets = d & 1; m_hi = (d >> 1) & 1; end
        else if (a >= 8 && a < 13) m_wt[a-8] = d & 32'hffff;
        else if (a >= 16 && a < 21) m_bd[a-16] = d & 32'hffff;
    endtask

    task automatic sweep(input int hold, input string ph);
        for (int p = 0; p < 32; p++)
            for (int r = 0; r < hold; r++)
                drive(NC'(p), ph);
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 grant in reset", gnt, '0);
        rst_n = 1'b1;

        // Phase A: reset configuration only (R1)
        sweep(12, "R1 defaults");

        // Phase B: pure round-robin (R5)
        cfg_wr(3, 0);
        cfg_wr(2, 0);
        sweep(7, "R5 R9 pure rotation");

        // Phase C: remapped table with an invalid top entry, weighted-fair off (R3, R8)
        cfg_wr(0, (7 << 12) | (3 << 9) | (0 << 6) | (4 << 3) | 2);
        cfg_wr(1, 32'h05);
        cfg_wr(2, 32'h18);
        cfg_wr(3, 2);
        cfg_wr(4, 2);
        sweep(8, "R3 R8 R9 remap");

        // Phase D: overlap of strict and weighted-fair sets (R10)
        cfg_wr(0, 32'h4688);
        cfg_wr(4, 1);
        cfg_wr(1, 32'h09);
        cfg_wr(3, 3);
        sweep(8, "R10 R9 overlap");

        // Phase E: unequal weights and a bound below its weight (R7)
        cfg_wr(1, 0);
        cfg_wr(2, 32'h1E);
        cfg_wr(3, 1);
        cfg_wr(9, 32'h0400);
        cfg_wr(10, 32'h0800);
        cfg_wr(11, 32'h1000);
        cfg_wr(12, 32'h3000);
        cfg_wr(20, 32'h1800);
        sweep(10, "R7 R9 weights");

        drive('0, "R2 idle");
        drive('0, "R2 idle");
        summary();
        $finish;
    end
endmodule